// File: doc/BRIEF.md
# Control Word Loader for a Frequency Synthesizer

This block sits on the host side of a numerically controlled oscillator. It collects a 40-bit word on a host write clock, either as five bytes or as forty single bits. The word holds a 32-bit tuning value, a 5-bit phase offset and three control flags. The write clock has no fixed relation to the system clock.

The bits collect in a holding register. A separate update strobe, which is also asynchronous, is passed through a two-flop synchronizer into the system clock domain. On its rising edge the holding register is copied into the active register, and the active register drives all outputs. The format flag in the committed word decides whether the next load arrives as bytes or as serial bits. Reset always returns the block to byte loading.

Top module: `ctl_word_loader`

## Requirements
- R1: In byte mode, five rising edges of `wclk` each take one byte from `din`. The first byte is the control byte: bits [7:3] are the phase, bit 2 is power-down, bit 1 is the format flag and bit 0 is the multiplier enable. The next four bytes form the tuning word, most significant byte first.
- R2: The committed format flag appears on `serial_mode`. While it is 1, loading uses serial format.
- R3: In serial mode, each rising edge of `wclk` takes `din[7]`, least significant bit first. The first bit becomes tuning bit 0. The 40th bit becomes phase bit 4, which is bit 39 of the word.
- R4: Writes after the fifth byte, and serial bits after the fortieth, leave the holding register unchanged until the next strobe.
- R5: While `upd` is high, the write position returns to the start, so the next load begins again at the control byte or at tuning bit 0.
- R6: The outputs change only on a rising edge of `upd`, which passes through a two-flop synchronizer. They show the new word from the third rising `sys_clk` edge after `upd` rises, and they hold their value between strobes.
- R7: Reset clears the holding register, the active register and all outputs to zero, which selects byte mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System reference clock |
| rst | input | 1 | Asynchronous reset, active high |
| wclk | input | 1 | Host write clock |
| din | input | 8 | Byte data; bit 7 is the serial line |
| upd | input | 1 | Asynchronous update strobe |
| ftw | output | 32 | Committed tuning word |
| phase | output | 5 | Committed phase offset |
| pwr_down | output | 1 | Committed power-down flag |
| mult_en | output | 1 | Committed clock multiplier enable |
| serial_mode | output | 1 | Committed format flag, 1 for serial |

## Verification
The assertions assume that `wclk` stays idle while `upd` is high, and until the synchronizer has taken the strobe. This means the holding register is stable whenever the system domain copies it, and the format flag does not change during a write. The bench respects this by holding `upd` high for five system cycles with no write, and by waiting several cycles before and after each strobe. It changes `din` only while `wclk` is low.

// File: rtl/ctl_word_loader.sv
module ctl_word_loader #(
  parameter int FTW_W = 32,
  parameter int PH_W  = 5,
  parameter int BW    = 8
) (
  input  logic             sys_clk,
  input  logic             rst,
  input  logic             wclk,
  input  logic [BW-1:0]    din,
  input  logic             upd,
  output logic [FTW_W-1:0] ftw,
  output logic [PH_W-1:0]  phase,
  output logic             pwr_down,
  output logic             mult_en,
  output logic             serial_mode
);
  localparam int NB = FTW_W / BW + 1;
  localparam int W  = NB * BW;
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  hold, act;
  logic [CW-1:0] cnt, lim;
  logic [2:0]    sy;
  logic          cnt_clr, commit;

  assign cnt_clr = rst | upd;
  assign lim     = serial_mode ? CW'(W) : CW'(NB);

  always_ff @(posedge wclk or posedge cnt_clr)
    if (cnt_clr)        cnt <= '0;
    else if (cnt < lim) cnt <= cnt + 1'b1;

  always_ff @(posedge wclk or posedge rst)
    if (rst) hold <= '0;
    else if (cnt < lim) begin
      if (serial_mode) hold <= {din[BW-1], hold[W-1:1]};
      else
        for (int i = 0; i < NB; i++)
          if (cnt == CW'(i)) hold[(NB-1-i)*BW +: BW] <= din;
    end

  always_ff @(posedge sys_clk or posedge rst)
    if (rst) sy <= '0;
    else     sy <= {sy[1:0], upd};

  assign commit = sy[1] & ~sy[2];

  always_ff @(posedge sys_clk or posedge rst)
    if (rst)         act <= '0;
    else if (commit) act <= hold;

  assign ftw         = act[FTW_W-1:0];
  assign phase       = act[W-1 -: PH_W];
  assign pwr_down    = act[W-BW+2];
  assign serial_mode = act[W-BW+1];
  assign mult_en     = act[W-BW];

  AST_STROBE_ONE_CYCLE: assert property (@(posedge sys_clk) disable iff (rst) commit |=> !commit); // R6
  AST_OUT_HOLD: assert property (@(posedge sys_clk) disable iff (rst) !sy[1] |=> $stable({phase, pwr_down, serial_mode, mult_en, ftw})); // R6
  AST_FULL_IGNORED: assert property (@(posedge wclk) disable iff (cnt_clr) (!serial_mode && cnt == CW'(NB)) |=> $stable(hold)); // R4
  AST_SER_FULL_IGNORED: assert property (@(posedge wclk) disable iff (cnt_clr) (serial_mode && cnt == CW'(W)) |=> $stable(hold)); // R4
  AST_CNT_RANGE: assert property (@(posedge wclk) disable iff (rst) cnt <= CW'(W)); // R5
endmodule

// File: tb/sim_ctl_word_loader.sv
module sim_ctl_word_loader;
  logic        sys_clk = 0, rst = 1, wclk = 0, upd = 0;
  logic [7:0]  din = 0;
  logic [31:0] ftw;
  logic [4:0]  phase;
  logic        pwr_down, mult_en, serial_mode;
  int          total = 0, fails = 0, cyc = 0;

  ctl_word_loader u0 (.sys_clk(sys_clk), .rst(rst), .wclk(wclk), .din(din), .upd(upd),
    .ftw(ftw), .phase(phase), .pwr_down(pwr_down), .mult_en(mult_en), .serial_mode(serial_mode));

  always #10 sys_clk = ~sys_clk;

  localparam logic [39:0] VEC [4] = '{40'hA8_12345678, 40'h05_DEADBEEF,
                                      40'hF9_00000001, 40'h00_FFFFFFFF};

  always @(posedge sys_clk) begin
    cyc++;
    if (cyc == 100000) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic wpulse(input logic [7:0] b);
    din = b; #20 wclk = 1; #20 wclk = 0; #10;
  endtask

  task automatic load_par(input logic [39:0] w);
    for (int i = 4; i >= 0; i--) wpulse(w[i*8 +: 8]);
  endtask

  task automatic load_ser(input logic [39:0] w);
    for (int i = 0; i < 40; i++) wpulse({w[i], 7'b0});
  endtask

  task automatic strobe;
    upd = 1; repeat (5) @(negedge sys_clk); upd = 0; repeat (3) @(negedge sys_clk);
  endtask

  task automatic chk(input logic [39:0] exp, input string req);
    logic [39:0] got;
    got = {phase, pwr_down, serial_mode, mult_en, ftw};
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge sys_clk);
    chk(40'h0, "R7 reset state");
    rst = 0;
    @(negedge sys_clk);
    for (int k = 0; k < 4; k++) begin
      load_par(VEC[k]);
      strobe();
      chk(VEC[k], "R1 byte load");
    end
    load_par(40'h50_CAFEF00D);
    repeat (6) @(negedge sys_clk);
    chk(VEC[3], "R6 no commit before strobe");
    upd = 1;
    @(negedge sys_clk); @(negedge sys_clk);
    chk(VEC[3], "R6 two edges after strobe still old");
    @(negedge sys_clk);
    chk(40'h50_CAFEF00D, "R6 third edge shows new word");
    upd = 0; repeat (3) @(negedge sys_clk);
    load_par(40'h18_11223344);
    wpulse(8'hFF); wpulse(8'hEE);
    strobe();
    chk(40'h18_11223344, "R4 extra bytes ignored");
    load_par(40'h60_55667788);
    strobe();
    chk(40'h60_55667788, "R5 counter restarted after strobe");
    load_par(40'h02_0000ABCD);
    strobe();
    total++;
    if (serial_mode !== 1'b1) begin
      fails++; $display("FAIL R2: serial_mode %b expected 1", serial_mode);
    end
    load_ser(40'h8E_13579BDF);
    wpulse(8'h80); wpulse(8'h80); wpulse(8'h00);
    strobe();
    chk(40'h8E_13579BDF, "R3 serial LSB-first load, R4 extra bits ignored");
    load_ser(40'h31_0F0F0F0F);
    strobe();
    chk(40'h31_0F0F0F0F, "R2 serial word returns to byte mode");
    load_par(40'hC4_A5A5A5A5);
    strobe();
    chk(40'hC4_A5A5A5A5, "R1 byte load after serial");
    rst = 1; @(negedge sys_clk);
    chk(40'h0, "R7 reset clears outputs");
    rst = 0; @(negedge sys_clk);
    strobe();
    chk(40'h0, "R7 holding register cleared by reset");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule